// File: doc/BRIEF.md
# RV32I Instruction Decoder With Immediate Generation

This block is a purely combinational decoder for 32-bit base-integer RISC-V instructions. It takes one instruction word and first settles its encoding format from the seven opcode bits. From that format it pulls out the three register index fields and builds the sign-extended 32-bit immediate. In parallel it resolves the exact operation from the opcode, funct3 and funct7 fields and reports it as one bit of a one-hot vector.

For each field it also tells a downstream pipeline stage whether that field carries meaning for the instruction. A hazard or forwarding unit can then compare only the register indices that the instruction really reads or writes. Encodings outside the base set raise an illegal flag. When that flag is high, the operation vector and all validity flags stay low, so an illegal word can never look like a register access.

Top module: `rvd_decoder`

## Requirements
- R1: `fmt_o` depends only on `instr_i[6:0]`: 0110011 gives 0 (R); 0010011, 0000011, 1100111, 0001111 and 1110011 give 1 (I); 0100011 gives 2 (S); 1100011 gives 3 (B); 0110111 and 0010111 give 4 (U); 1101111 gives 5 (J); any other value gives 7.
- R2: `rs1_o`, `rs2_o` and `rd_o` always equal `instr_i[19:15]`, `instr_i[24:20]` and `instr_i[11:7]`, whatever the format or legality.
- R3: `imm_o` is sign-extended from `instr_i[31]`. For I it takes bits 31:20. For S it takes bits 31:25 above bits 11:7. For B it is {31, 7, 30:25, 11:8, 0}. For J it is {31, 19:12, 20, 30:21, 0}. For U it is bits 31:12 followed by twelve zeros. For R and unknown opcodes it is zero.
- R4: A B- or J-format immediate always has bit 0 clear, and a U-format immediate always has bits 11:0 clear.
- R5: `op_onehot_o` carries one bit per operation, in this order from bit 0: lui, auipc, jal, jalr, beq, bne, blt, bge, bltu, bgeu, lb, lh, lw, lbu, lhu, sb, sh, sw, addi, slti, sltiu, xori, ori, andi, slli, srli, srai, add, sub, sll, slt, sltu, xor, srl, sra, or, and, fence, ecall, ebreak. A legal word sets exactly one bit and an illegal word sets none.
- R6: On the register-register opcode, funct7 0000000 selects add, srl and the other operations, and funct7 0100000 selects sub (funct3 000) or sra (funct3 101). On the immediate-arithmetic opcode, slli and srli need funct7 0000000 and srai needs 0100000. Any other funct7 on these encodings is illegal.
- R7: `illegal_o` is high in these cases: `instr_i[1:0]` is not 11; the opcode is not listed in R1; funct3 is 010 or 011 on a branch; funct3 is 011, 110 or 111 on a load; funct3 is above 010 on a store; funct3 is nonzero on jalr or fence; or a system-opcode word is neither 0x00000073 (ecall) nor 0x00100073 (ebreak).
- R8: `rd_vld_o` is high only for a legal R, I, U or J instruction whose rd field is nonzero.
- R9: `rs1_vld_o` is high for a legal R, I, S or B instruction. `rs2_vld_o` is high for a legal R, S or B instruction.
- R10: `imm_vld_o` is high for a legal instruction of any format except R.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to decode |
| fmt_o | output | 3 | Format code (see R1) |
| rs1_o | output | 5 | First source register index |
| rs2_o | output | 5 | Second source register index |
| rd_o | output | 5 | Destination register index |
| imm_o | output | 32 | Sign-extended immediate |
| op_onehot_o | output | 40 | One-hot operation vector (see R5) |
| rs1_vld_o | output | 1 | rs1 is read by the instruction |
| rs2_vld_o | output | 1 | rs2 is read by the instruction |
| rd_vld_o | output | 1 | rd is written by the instruction |
| imm_vld_o | output | 1 | Immediate is used by the instruction |
| illegal_o | output | 1 | Encoding is outside the base set |

## Verification
The bench builds the decoder with its package defaults: a 32-bit instruction and immediate, 5-bit register indices and 40 operations. That fixed size is small enough to sweep every one of the 128 opcode values against all eight funct3 values and five funct7 patterns. The funct7 patterns cover zero, the alternate-operation bit, a stray low bit and sign-bit-set values, and each is tried with three register-field patterns. This reaches every legal operation, every funct3 hole, every misplaced funct7 and both immediate signs. Directed words then pin exact immediate values at their extremes, along with the two system encodings and their near misses.

// File: rtl/rvd_pkg.sv
package rvd_pkg;

    localparam int ILEN     = 32;
    localparam int XLEN     = 32;
    localparam int REG_AW   = 5;
    localparam int NUM_OPS  = 40;
    localparam int OPC_W    = 7;
    localparam int OP_IDX_W = $clog2(NUM_OPS);

    typedef enum logic [2:0] {
        FMT_R    = 3'd0,
        FMT_I    = 3'd1,
        FMT_S    = 3'd2,
        FMT_B    = 3'd3,
        FMT_U    = 3'd4,
        FMT_J    = 3'd5,
        FMT_NONE = 3'd7
    } fmt_e;

    localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
    localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;
    localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
    localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
    localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
    localparam logic [OPC_W-1:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [OPC_W-1:0] OPC_OP     = 7'b0110011;
    localparam logic [OPC_W-1:0] OPC_FENCE  = 7'b0001111;
    localparam logic [OPC_W-1:0] OPC_SYSTEM = 7'b1110011;

    localparam logic [ILEN-1:0] WORD_ECALL  = 32'h0000_0073;
    localparam logic [ILEN-1:0] WORD_EBREAK = 32'h0010_0073;

    // Bit position of each operation in the one-hot output.
    typedef enum logic [OP_IDX_W-1:0] {
        OP_LUI, OP_AUIPC, OP_JAL, OP_JALR,
        OP_BEQ, OP_BNE, OP_BLT, OP_BGE, OP_BLTU, OP_BGEU,
        OP_LB, OP_LH, OP_LW, OP_LBU, OP_LHU,
        OP_SB, OP_SH, OP_SW,
        OP_ADDI, OP_SLTI, OP_SLTIU, OP_XORI, OP_ORI, OP_ANDI,
        OP_SLLI, OP_SRLI, OP_SRAI,
        OP_ADD, OP_SUB, OP_SLL, OP_SLT, OP_SLTU, OP_XOR,
        OP_SRL, OP_SRA, OP_OR, OP_AND,
        OP_FENCE, OP_ECALL, OP_EBREAK
    } op_e;

    typedef struct packed {
        op_e  op;
        logic illegal;
    } op_res_t;

    function automatic fmt_e fmt_of(input logic [OPC_W-1:0] opc);
        unique case (opc)
            OPC_OP:                                    return FMT_R;
            OPC_OPIMM, OPC_LOAD, OPC_JALR,
            OPC_FENCE, OPC_SYSTEM:                     return FMT_I;
            OPC_STORE:                                 return FMT_S;
            OPC_BRANCH:                                return FMT_B;
            OPC_LUI, OPC_AUIPC:                        return FMT_U;
            OPC_JAL:                                   return FMT_J;
            default:                                   return FMT_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rvd_fmt_classify.sv
module rvd_fmt_classify
    import rvd_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output fmt_e             fmt_o
);

    assign fmt_o = fmt_of(opcode_i);

endmodule

// File: rtl/rvd_imm_gen.sv
module rvd_imm_gen
    import rvd_pkg::*;
(
    input  logic [ILEN-1:7] bits_i,
    input  fmt_e            fmt_i,
    output logic [XLEN-1:0] imm_o
);

    logic sgn;
    assign sgn = bits_i[31];

    always_comb begin
        unique case (fmt_i)
            FMT_I:   imm_o = {{(XLEN-12){sgn}}, bits_i[31:20]};
            FMT_S:   imm_o = {{(XLEN-12){sgn}}, bits_i[31:25], bits_i[11:7]};
            FMT_B:   imm_o = {{(XLEN-12){sgn}}, bits_i[7], bits_i[30:25],
                              bits_i[11:8], 1'b0};
            FMT_U:   imm_o = {bits_i[31:12], 12'b0};
            FMT_J:   imm_o = {{(XLEN-20){sgn}}, bits_i[19:12], bits_i[20],
                              bits_i[30:21], 1'b0};
            default: imm_o = '0;
        endcase
    end

endmodule

// File: rtl/rvd_op_decode.sv
module rvd_op_decode
    import rvd_pkg::*;
(
    input  logic [ILEN-1:0] instr_i,
    output op_res_t         res_o
);

    logic [OPC_W-1:0] opc;
    logic [2:0]       f3;
    logic [6:0]       f7;
    logic             f7_zero;
    logic             f7_alt;

    assign opc     = instr_i[6:0];
    assign f3      = instr_i[14:12];
    assign f7      = instr_i[31:25];
    assign f7_zero = (f7 == 7'b0000000);
    assign f7_alt  = (f7 == 7'b0100000);

    always_comb begin
        res_o.op      = OP_ADD;
        res_o.illegal = 1'b0;
        if (instr_i[1:0] != 2'b11) begin
            res_o.illegal = 1'b1;
        end else begin
            unique case (opc)
                OPC_LUI:   res_o.op = OP_LUI;
                OPC_AUIPC: res_o.op = OP_AUIPC;
                OPC_JAL:   res_o.op = OP_JAL;
                OPC_JALR: begin
                    res_o.op      = OP_JALR;
                    res_o.illegal = (f3 != 3'b000);
                end
                OPC_BRANCH: begin
                    unique case (f3)
                        3'b000:  res_o.op = OP_BEQ;
                        3'b001:  res_o.op = OP_BNE;
                        3'b100:  res_o.op = OP_BLT;
                        3'b101:  res_o.op = OP_BGE;
                        3'b110:  res_o.op = OP_BLTU;
                        3'b111:  res_o.op = OP_BGEU;
                        default: res_o.illegal = 1'b1;
                    endcase
                end
                OPC_LOAD: begin
                    unique case (f3)
                        3'b000:  res_o.op = OP_LB;
                        3'b001:  res_o.op = OP_LH;
                        3'b010:  res_o.op = OP_LW;
                        3'b100:  res_o.op = OP_LBU;
                        3'b101:  res_o.op = OP_LHU;
                        default: res_o.illegal = 1'b1;
                    endcase
                end
                OPC_STORE: begin
                    unique case (f3)
                        3'b000:  res_o.op = OP_SB;
                        3'b001:  res_o.op = OP_SH;
                        3'b010:  res_o.op = OP_SW;
                        default: res_o.illegal = 1'b1;
                    endcase
                end
                OPC_OPIMM: begin
                    unique case (f3)
                        3'b000: res_o.op = OP_ADDI;
                        3'b010: res_o.op = OP_SLTI;
                        3'b011: res_o.op = OP_SLTIU;
                        3'b100: res_o.op = OP_XORI;
                        3'b110: res_o.op = OP_ORI;
                        3'b111: res_o.op = OP_ANDI;
                        3'b001: begin
                            res_o.op      = OP_SLLI;
                            res_o.illegal = !f7_zero;
                        end
                        default: begin
                            res_o.op      = f7_alt ? OP_SRAI : OP_SRLI;
                            res_o.illegal = !(f7_zero || f7_alt);
                        end
                    endcase
                end
                OPC_OP: begin
                    unique case (f3)
                        3'b000: begin
                            res_o.op      = f7_alt ? OP_SUB : OP_ADD;
                            res_o.illegal = !(f7_zero || f7_alt);
                        end
                        3'b101: begin
                            res_o.op      = f7_alt ? OP_SRA : OP_SRL;
                            res_o.illegal = !(f7_zero || f7_alt);
                        end
                        default: begin
                            res_o.illegal = !f7_zero;
                            unique case (f3)
                                3'b001:  res_o.op = OP_SLL;
                                3'b010:  res_o.op = OP_SLT;
                                3'b011:  res_o.op = OP_SLTU;
                                3'b100:  res_o.op = OP_XOR;
                                3'b110:  res_o.op = OP_OR;
                                default: res_o.op = OP_AND;
                            endcase
                        end
                    endcase
                end
                OPC_FENCE: begin
                    res_o.op      = OP_FENCE;
                    res_o.illegal = (f3 != 3'b000);
                end
                OPC_SYSTEM: begin
                    if (instr_i == WORD_ECALL)
                        res_o.op = OP_ECALL;
                    else if (instr_i == WORD_EBREAK)
                        res_o.op = OP_EBREAK;
                    else
                        res_o.illegal = 1'b1;
                end
                default: res_o.illegal = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/rvd_decoder.sv
module rvd_decoder
    import rvd_pkg::*;
(
    input  logic [ILEN-1:0]    instr_i,
    output logic [2:0]         fmt_o,
    output logic [REG_AW-1:0]  rs1_o,
    output logic [REG_AW-1:0]  rs2_o,
    output logic [REG_AW-1:0]  rd_o,
    output logic [XLEN-1:0]    imm_o,
    output logic [NUM_OPS-1:0] op_onehot_o,
    output logic               rs1_vld_o,
    output logic               rs2_vld_o,
    output logic               rd_vld_o,
    output logic               imm_vld_o,
    output logic               illegal_o
);

    fmt_e    fmt;
    op_res_t opr;
    logic    legal;

    rvd_fmt_classify u_fmt (
        .opcode_i (instr_i[OPC_W-1:0]),
        .fmt_o    (fmt)
    );

    rvd_imm_gen u_imm (
        .bits_i (instr_i[ILEN-1:7]),
        .fmt_i  (fmt),
        .imm_o  (imm_o)
    );

    rvd_op_decode u_op (
        .instr_i (instr_i),
        .res_o   (opr)
    );

    assign legal = !opr.illegal;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_onehot
        assign op_onehot_o[g] = legal && (opr.op == op_e'(g));
    end

    assign fmt_o     = fmt;
    assign rs1_o     = instr_i[19:15];
    assign rs2_o     = instr_i[24:20];
    assign rd_o      = instr_i[11:7];
    assign illegal_o = opr.illegal;

    always_comb begin
        rs1_vld_o = 1'b0;
        rs2_vld_o = 1'b0;
        rd_vld_o  = 1'b0;
        imm_vld_o = 1'b0;
        if (legal) begin
            unique case (fmt)
                FMT_R: begin
                    rs1_vld_o = 1'b1;
                    rs2_vld_o = 1'b1;
                    rd_vld_o  = 1'b1;
                end
                FMT_I: begin
                    rs1_vld_o = 1'b1;
                    rd_vld_o  = 1'b1;
                    imm_vld_o = 1'b1;
                end
                FMT_S, FMT_B: begin
                    rs1_vld_o = 1'b1;
                    rs2_vld_o = 1'b1;
                    imm_vld_o = 1'b1;
                end
                FMT_U, FMT_J: begin
                    rd_vld_o  = 1'b1;
                    imm_vld_o = 1'b1;
                end
                default: ;
            endcase
            if (rd_o == '0) rd_vld_o = 1'b0;
        end
    end

endmodule

// File: rtl/rvd_decoder_chk.sv
module rvd_decoder_chk
    import rvd_pkg::*;
(
    input logic [ILEN-1:0]    instr_i,
    input logic [2:0]         fmt_o,
    input logic [REG_AW-1:0]  rd_o,
    input logic [XLEN-1:0]    imm_o,
    input logic [NUM_OPS-1:0] op_onehot_o,
    input logic               rs1_vld_o,
    input logic               rs2_vld_o,
    input logic               rd_vld_o,
    input logic               imm_vld_o,
    input logic               illegal_o
);

    always_comb begin
        if (!$isunknown(instr_i)) begin
            // R5: at most one operation, and none exactly when illegal
            p_onehot_r5: assert ($onehot0(op_onehot_o) &&
                                 (illegal_o == (op_onehot_o == '0)))
                else $error("R5 one-hot violated");
            // R7: low opcode bits other than 11 are never legal
            p_lowbits_r7: assert ((instr_i[1:0] == 2'b11) || illegal_o)
                else $error("R7 low bits accepted");
            // R7: an illegal word exposes no field as meaningful
            p_quiet_r7: assert (!illegal_o ||
                                !(rs1_vld_o || rs2_vld_o || rd_vld_o || imm_vld_o))
                else $error("R7 validity on illegal word");
            // R4: branch and jump offsets are even
            p_even_r4: assert (!((fmt_o == 3'd3) || (fmt_o == 3'd5)) || !imm_o[0])
                else $error("R4 odd offset");
            // R4: upper immediates have a clear low field
            p_ulow_r4: assert ((fmt_o != 3'd4) || (imm_o[11:0] == '0))
                else $error("R4 upper immediate low bits");
            // R8: x0 is never reported as a written destination
            p_rdzero_r8: assert (!rd_vld_o || (rd_o != '0))
                else $error("R8 rd zero reported");
            // R9: rs2 only for R, S and B
            p_rs2fmt_r9: assert (!rs2_vld_o || (fmt_o == 3'd0) ||
                                 (fmt_o == 3'd2) || (fmt_o == 3'd3))
                else $error("R9 rs2 on wrong format");
            // R10: R-format never exposes an immediate
            p_rimm_r10: assert (!((fmt_o == 3'd0) && imm_vld_o))
                else $error("R10 immediate on R format");
        end
    end

endmodule

bind rvd_decoder rvd_decoder_chk chk_i (
    .instr_i     (instr_i),
    .fmt_o       (fmt_o),
    .rd_o        (rd_o),
    .imm_o       (imm_o),
    .op_onehot_o (op_onehot_o),
    .rs1_vld_o   (rs1_vld_o),
    .rs2_vld_o   (rs2_vld_o),
    .rd_vld_o    (rd_vld_o),
    .imm_vld_o   (imm_vld_o),
    .illegal_o   (illegal_o)
);

// File: tb/rvd_decoder_tb_top.sv
module rvd_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr;
    logic [2:0]  fmt;
    logic [4:0]  rs1, rs2, rd;
    logic [31:0] imm;
    logic [39:0] onehot;
    logic        rs1_vld, rs2_vld, rd_vld, imm_vld, illegal;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    rvd_decoder dut_i (
        .instr_i     (instr),
        .fmt_o       (fmt),
        .rs1_o       (rs1),
        .rs2_o       (rs2),
        .rd_o        (rd),
        .imm_o       (imm),
        .op_onehot_o (onehot),
        .rs1_vld_o   (rs1_vld),
        .rs2_vld_o   (rs2_vld),
        .rd_vld_o    (rd_vld),
        .imm_vld_o   (imm_vld),
        .illegal_o   (illegal)
    );

    function automatic int exp_fmt(input logic [31:0] w);
        case (w[6:0])
            7'b0110011:                                     return 0;
            7'b0010011, 7'b0000011, 7'b1100111,
            7'b0001111, 7'b1110011:                         return 1;
            7'b0100011:                                     return 2;
            7'b1100011:                                     return 3;
            7'b0110111, 7'b0010111:                         return 4;
            7'b1101111:                                     return 5;
            default:                                        return 7;
        endcase
    endfunction

    // Operation index per R5 order, -1 when illegal (R6, R7)
    function automatic int exp_op(input logic [31:0] w);
        if (w == 32'h0000_0073) return 38;
        if (w == 32'h0010_0073) return 39;
        casez ({w[31:25], w[14:12], w[6:0]})
            17'b???????_???_0110111: return 0;
            17'b???????_???_0010111: return 1;
            17'b???????_???_1101111: return 2;
            17'b???????_000_1100111: return 3;
            17'b???????_000_1100011: return 4;
            17'b???????_001_1100011: return 5;
            17'b???????_100_1100011: return 6;
            17'b???????_101_1100011: return 7;
            17'b???????_110_1100011: return 8;
            17'b???????_111_1100011: return 9;
            17'b???????_000_0000011: return 10;
            17'b???????_001_0000011: return 11;
            17'b???????_010_0000011: return 12;
            17'b???????_100_0000011: return 13;
            17'b???????_101_0000011: return 14;
            17'b???????_000_0100011: return 15;
            17'b???????_001_0100011: return 16;
            17'b???????_010_0100011: return 17;
            17'b???????_000_0010011: return 18;
            17'b???????_010_0010011: return 19;
            17'b???????_011_0010011: return 20;
            17'b???????_100_0010011: return 21;
            17'b???????_110_0010011: return 22;
            17'b???????_111_0010011: return 23;
            17'b0000000_001_0010011: return 24;
            17'b0000000_101_0010011: return 25;
            17'b0100000_101_0010011: return 26;
            17'b0000000_000_0110011: return 27;
            17'b0100000_000_0110011: return 28;
            17'b0000000_001_0110011: return 29;
            17'b0000000_010_0110011: return 30;
            17'b0000000_011_0110011: return 31;
            17'b0000000_100_0110011: return 32;
            17'b0000000_101_0110011: return 33;
            17'b0100000_101_0110011: return 34;
            17'b0000000_110_0110011: return 35;
            17'b0000000_111_0110011: return 36;
            17'b???????_000_0001111: return 37;
            default:                 return -1;
        endcase
    endfunction

    function automatic logic [31:0] exp_imm(input logic [31:0] w);
        logic signed [31:0] s;
        s = $signed(w);
        case (exp_fmt(w))
            1: return 32'(s >>> 20);
            2: return 32'((s >>> 25) <<< 5) | 32'(w[11:7]);
            3: return 32'((s >>> 31) <<< 12) | (32'(w[7]) << 11) |
                      (32'(w[30:25]) << 5) | (32'(w[11:8]) << 1);
            4: return w & 32'hFFFF_F000;
            5: return 32'((s >>> 31) <<< 20) | (32'(w[19:12]) << 12) |
                      (32'(w[20]) << 11) | (32'(w[30:21]) << 1);
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp,
                       input logic [31:0] w);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s instr=%08h actual=%0h expected=%0h",
                     req, what, w, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] w);
        int          op;
        int          f;
        logic [39:0] oh;
        bit          lg;
        @(negedge clk);
        instr = w;
        #1;
        op = exp_op(w);
        f  = exp_fmt(w);
        lg = (op >= 0);
        oh = lg ? (40'd1 << op) : 40'd0;
        chk(fmt == 3'(f), "R1", "fmt", 64'(fmt), 64'(f), w);
        chk({rs1, rs2, rd} == {w[19:15], w[24:20], w[11:7]}, "R2", "regs",
            64'({rs1, rs2, rd}), 64'({w[19:15], w[24:20], w[11:7]}), w);
        chk(imm == exp_imm(w), "R3/R4", "imm", 64'(imm), 64'(exp_imm(w)), w);
        chk(onehot == oh, "R5/R6", "op", 64'(onehot), 64'(oh), w);
        chk(illegal == !lg, "R7", "illegal", 64'(illegal), 64'(!lg), w);
        chk(rd_vld == (lg && (f == 0 || f == 1 || f == 4 || f == 5) && w[11:7] != 0),
            "R8", "rd_vld", 64'(rd_vld), 64'(!rd_vld), w);
        chk({rs1_vld, rs2_vld} == {lg && f <= 3, lg && (f == 0 || f == 2 || f == 3)},
            "R9", "rs_vld", 64'({rs1_vld, rs2_vld}),
            64'({lg && f <= 3, lg && (f == 0 || f == 2 || f == 3)}), w);
        chk(imm_vld == (lg && f >= 1 && f <= 5), "R10", "imm_vld",
            64'(imm_vld), 64'(!imm_vld), w);
    endtask

    task automatic apply_imm(input logic [31:0] w, input logic [31:0] v);
        @(negedge clk);
        instr = w;
        #1;
        chk(imm == v, "R3", "imm-directed", 64'(imm), 64'(v), w);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                fails++;
                $display("FAIL watchdog cycles actual=%0d expected<=150000", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
                $finish;
            end
        end
    end

    initial begin : stim
        logic [6:0] f7s [5];
        logic [14:0] regs [3];
        f7s[0] = 7'h00; f7s[1] = 7'h20; f7s[2] = 7'h01; f7s[3] = 7'h60; f7s[4] = 7'h7F;
        regs[0] = {5'd0, 5'd0, 5'd0};
        regs[1] = {5'd31, 5'd17, 5'd5};
        regs[2] = {5'd2, 5'd1, 5'd31};
        instr = 32'h0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Initial state: the all-zero word is illegal (R7) with no op (R5)
        @(negedge clk);
        #1;
        chk(illegal && onehot == 0 && !rd_vld && !imm_vld, "R7", "reset-zero-word",
            64'({illegal, onehot}), 64'({1'b1, 40'd0}), instr);
        // Near-exhaustive sweep: opcode x funct3 x funct7 x register pattern
        for (int o = 0; o < 128; o++)
            for (int f3 = 0; f3 < 8; f3++)
                for (int k = 0; k < 5; k++)
                    for (int p = 0; p < 3; p++)
                        apply({f7s[k], regs[p][14:10], regs[p][9:5], 3'(f3),
                               regs[p][4:0], 7'(o)});
        // System words and near misses (R7)
        apply(32'h0000_0073);
        apply(32'h0010_0073);
        apply(32'h0020_0073);
        apply(32'h0000_00F3);
        apply(32'h0000_1073);
        apply(32'h0000_0072);
        // Directed immediate extremes (R3, R4)
        apply_imm(32'hFFF0_0093, 32'hFFFF_FFFF);   // addi x1,x0,-1
        apply_imm(32'h7FF0_0093, 32'h0000_07FF);   // addi max positive
        apply_imm(32'h8000_0013, 32'hFFFF_F800);   // I min
        apply_imm(32'hFE00_0FA3, 32'hFFFF_FFFF);   // sb offset -1
        apply_imm(32'h8000_0063, 32'hFFFF_F000);   // beq min offset
        apply_imm(32'h7E00_0FE3, 32'h0000_0FFE);   // beq max offset
        apply_imm(32'h8000_006F, 32'hFFF0_0000);   // jal min offset
        apply_imm(32'h7FFF_F06F, 32'h000F_FFFE);   // jal max offset
        apply_imm(32'hABCD_E0B7, 32'hABCD_E000);   // lui
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule